// File: doc/BRIEF.md
# Addressing-Mode Operand Fetch Unit

This unit resolves the operand of a one-address add instruction. It receives a three-bit mode code, a general-register selector, a short address field X and an index-update code. From these it forms an effective address, performs the memory reads that the mode requires on a synchronous single-port memory, and adds the operand to an accumulator. The unit owns a small register file: the accumulator, several general address registers, one index register and one base register. A load port fills these registers while the unit is idle.

Indirect mode can chain. When a fetched pointer word has its top bit set, the unit follows it again. A parameter caps the number of pointer reads. A chain that reaches the cap ends with an error pulse, and no register changes. The index register can be stepped up or down by one as a side effect of a successful operation. The step uses the old value for the address.

The memory returns read data one clock after it samples `mem_rd`. The unit drives `mem_rd` and `mem_addr` from its own state registers.

Top module: `operand_fetch_unit`

## Requirements
- R1: After a synchronous reset the accumulator, index register, base register and general registers are zero, and `busy`, `done`, `err` and `mem_rd` are low.
- R2: The mode codes are 0 immediate, 1 direct, 2 indirect, 3 register-indirect, 4 register-memory-indirect, 5 base+displacement, 6 indexed and 7 base+index. The operand is, in the same order: X zero-extended, M[X], M[M[X]], M[Ri], M[M[Ri]], M[Rb+X], M[X+Rx] and M[Rb+Rx+X]. Address sums wrap at the address width, and a fetched pointer supplies its low address-width bits as an address.
- R3: When an operation succeeds, the accumulator becomes its old value plus the operand, modulo 2^DW.
- R4: Immediate mode makes no memory read. Direct, register-indirect, base+displacement, indexed and base+index make exactly one. Register-memory-indirect makes two.
- R5: In indirect mode, a fetched pointer word with bit DW-1 set is itself used as the next pointer address. A pointer word with that bit clear addresses the operand. Only indirect mode follows this flag.
- R6: An indirect operation that reads MAX_IND pointer words, all with the flag set, ends with `err` high during its `done` cycle. That operation leaves the accumulator and the index register unchanged.
- R7: `busy` is high for 2·N+1 cycles, where N is the number of memory reads. It is followed by a single-cycle `done` pulse. `mem_rd` is only ever high while `busy` is high.
- R8: Index-update code 1 adds one to Rx and code 2 subtracts one, both modulo 2^AW. Codes 0 and 3 leave Rx alone. The effective address always uses the value Rx held before the step.
- R9: A `start` or a load that arrives while `busy` is high is ignored.
- R10: With AC=50, Rb=150, M[100]=200, M[200]=125 and M[250]=213, X=100 gives 250 in direct mode, 175 in indirect mode, 263 in base+displacement mode and 150 in immediate mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (sampled when idle) |
| mode_i | input | 3 | Addressing-mode code |
| idx_op_i | input | 2 | Index-update code |
| ri_sel_i | input | RW | General register selected as Ri |
| x_i | input | AW | Address field X |
| ld_en | input | 1 | Register load strobe (idle only) |
| ld_sel | input | 2 | Load target: 0 AC, 1 Rx, 2 Rb, 3 general register |
| ld_gpr | input | RW | General register index for target 3 |
| ld_data | input | DW | Load value (address registers keep low AW bits) |
| mem_rd | output | 1 | Memory read request |
| mem_addr | output | AW | Memory read address |
| mem_rdata | input | DW | Read data, valid the cycle after the request |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Indirection cap reached (with done) |
| acc_o | output | DW | Accumulator value |
| idx_o | output | AW | Index register value |

## Verification
The assertions rely on the memory returning data exactly one cycle after a sampled `mem_rd`. They also rely on `start` and loads being applied as idle-cycle strobes. The bench memory model reproduces that latency. The bench drives strobes only at falling edges, and it issues stray `start` and load pulses only in windows where `busy` is high. The bench fills memory with pointer-flag-free contents by default. It writes flagged words only at chosen cells, so each chain depth, including the cap, is reached deliberately.

// File: rtl/ofu_pkg.sv
package ofu_pkg;

    typedef enum logic [2:0] {
        AM_IMM    = 3'd0,
        AM_DIR    = 3'd1,
        AM_IND    = 3'd2,
        AM_RIND   = 3'd3,
        AM_RMIND  = 3'd4,
        AM_BDISP  = 3'd5,
        AM_INDEX  = 3'd6,
        AM_BINDEX = 3'd7
    } amode_e;

    typedef enum logic [1:0] {
        XS_NONE = 2'd0,
        XS_INC  = 2'd1,
        XS_DEC  = 2'd2,
        XS_NOP3 = 2'd3
    } xstep_e;

    typedef enum logic [1:0] {
        LT_AC  = 2'd0,
        LT_RX  = 2'd1,
        LT_RB  = 2'd2,
        LT_GPR = 2'd3
    } ldtgt_e;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_RD_PTR,
        SQ_PTR_DATA,
        SQ_RD_OPND,
        SQ_OPND_DATA,
        SQ_FINISH
    } seq_e;

    function automatic logic mode_chases_pointer(amode_e m);
        return (m == AM_IND) || (m == AM_RMIND);
    endfunction

    function automatic logic step_active(xstep_e s);
        return (s == XS_INC) || (s == XS_DEC);
    endfunction

endpackage

// File: rtl/ofu_regfile.sv
module ofu_regfile
    import ofu_pkg::*;
#(
    parameter int DW   = 16,
    parameter int AW   = 8,
    parameter int NGPR = 4,
    parameter int RW   = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ld_we,
    input  ldtgt_e        ld_tgt,
    input  logic [RW-1:0] ld_gpr,
    input  logic [DW-1:0] ld_data,
    input  logic          acc_we,
    input  logic [DW-1:0] acc_addend,
    input  logic          rx_we,
    input  logic          rx_down,
    input  logic [RW-1:0] ri_sel,
    output logic [DW-1:0] acc_q,
    output logic [AW-1:0] rx_q,
    output logic [AW-1:0] rb_q,
    output logic [AW-1:0] ri_q
);
    logic [AW-1:0] gpr_q [NGPR];

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else if (acc_we) begin
            acc_q <= acc_q + acc_addend;
        end else if (ld_we && ld_tgt == LT_AC) begin
            acc_q <= ld_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_q <= '0;
        end else if (rx_we) begin
            rx_q <= rx_down ? rx_q - AW'(1) : rx_q + AW'(1);
        end else if (ld_we && ld_tgt == LT_RX) begin
            rx_q <= ld_data[AW-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rb_q <= '0;
        end else if (ld_we && ld_tgt == LT_RB) begin
            rb_q <= ld_data[AW-1:0];
        end
    end

    for (genvar g = 0; g < NGPR; g++) begin : g_gpr
        always_ff @(posedge clk) begin
            if (rst) begin
                gpr_q[g] <= '0;
            end else if (ld_we && ld_tgt == LT_GPR && ld_gpr == RW'(g)) begin
                gpr_q[g] <= ld_data[AW-1:0];
            end
        end
    end

    assign ri_q = gpr_q[ri_sel];

endmodule

// File: rtl/ofu_agen.sv
module ofu_agen
    import ofu_pkg::*;
#(
    parameter int AW = 8
) (
    input  amode_e        mode,
    input  logic [AW-1:0] x_fld,
    input  logic [AW-1:0] ri_val,
    input  logic [AW-1:0] rx_val,
    input  logic [AW-1:0] rb_val,
    output logic [AW-1:0] first_addr
);
    always_comb begin
        unique case (mode)
            AM_RIND, AM_RMIND: first_addr = ri_val;
            AM_BDISP:          first_addr = rb_val + x_fld;
            AM_INDEX:          first_addr = x_fld + rx_val;
            AM_BINDEX:         first_addr = rb_val + rx_val + x_fld;
            default:           first_addr = x_fld;
        endcase
    end
endmodule

// File: rtl/ofu_seq.sv
module ofu_seq
    import ofu_pkg::*;
#(
    parameter int DW      = 16,
    parameter int AW      = 8,
    parameter int MAX_IND = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  amode_e        mode_in,
    input  xstep_e        step_in,
    input  logic [AW-1:0] x_in,
    input  logic [AW-1:0] first_addr,
    input  logic [DW-1:0] mem_rdata,
    output logic          mem_rd,
    output logic [AW-1:0] mem_addr,
    output logic          busy,
    output logic          done,
    output logic          err,
    output logic          acc_we,
    output logic [DW-1:0] operand,
    output logic          rx_we,
    output logic          rx_down
);
    localparam int CW = $clog2(MAX_IND) + 1;

    seq_e          st_q;
    amode_e        mode_q;
    xstep_e        step_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] opnd_q;
    logic [CW-1:0] ptr_cnt_q;
    logic          fail_q;

    logic ptr_flag;
    assign ptr_flag = (mode_q == AM_IND) && mem_rdata[DW-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= SQ_IDLE;
            mode_q    <= AM_IMM;
            step_q    <= XS_NONE;
            addr_q    <= '0;
            opnd_q    <= '0;
            ptr_cnt_q <= '0;
            fail_q    <= 1'b0;
            done      <= 1'b0;
            err       <= 1'b0;
        end else begin
            done <= 1'b0;
            err  <= 1'b0;
            unique case (st_q)
                SQ_IDLE: if (start) begin
                    mode_q    <= mode_in;
                    step_q    <= step_in;
                    ptr_cnt_q <= '0;
                    fail_q    <= 1'b0;
                    addr_q    <= first_addr;
                    if (mode_in == AM_IMM) begin
                        opnd_q <= DW'(x_in);
                        st_q   <= SQ_FINISH;
                    end else if (mode_chases_pointer(mode_in)) begin
                        st_q <= SQ_RD_PTR;
                    end else begin
                        st_q <= SQ_RD_OPND;
                    end
                end
                SQ_RD_PTR:  st_q <= SQ_PTR_DATA;
                SQ_PTR_DATA: begin
                    addr_q <= mem_rdata[AW-1:0];
                    if (!ptr_flag) begin
                        st_q <= SQ_RD_OPND;
                    end else if (ptr_cnt_q == CW'(MAX_IND - 1)) begin
                        fail_q <= 1'b1;
                        st_q   <= SQ_FINISH;
                    end else begin
                        ptr_cnt_q <= ptr_cnt_q + CW'(1);
                        st_q      <= SQ_RD_PTR;
                    end
                end
                SQ_RD_OPND: st_q <= SQ_OPND_DATA;
                SQ_OPND_DATA: begin
                    opnd_q <= mem_rdata;
                    st_q   <= SQ_FINISH;
                end
                SQ_FINISH: begin
                    done <= 1'b1;
                    err  <= fail_q;
                    st_q <= SQ_IDLE;
                end
                default: st_q <= SQ_IDLE;
            endcase
        end
    end

    assign busy     = (st_q != SQ_IDLE);
    assign mem_rd   = (st_q == SQ_RD_PTR) || (st_q == SQ_RD_OPND);
    assign mem_addr = addr_q;
    assign operand  = opnd_q;
    assign acc_we   = (st_q == SQ_FINISH) && !fail_q;
    assign rx_we    = acc_we && step_active(step_q);
    assign rx_down  = (step_q == XS_DEC);

    // R6
    ptr_depth_chk: assert property (@(posedge clk) disable iff (rst)
        ptr_cnt_q < CW'(MAX_IND));

    // R6
    err_with_done_chk: assert property (@(posedge clk) disable iff (rst)
        err |-> done);

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7
    rd_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rd |-> busy);

    // R7
    busy_end_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

endmodule

// File: rtl/operand_fetch_unit.sv
module operand_fetch_unit
    import ofu_pkg::*;
#(
    parameter int DW      = 16,
    parameter int AW      = 8,
    parameter int NGPR    = 4,
    parameter int MAX_IND = 4,
    localparam int RW     = (NGPR > 1) ? $clog2(NGPR) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [2:0]    mode_i,
    input  logic [1:0]    idx_op_i,
    input  logic [RW-1:0] ri_sel_i,
    input  logic [AW-1:0] x_i,
    input  logic          ld_en,
    input  logic [1:0]    ld_sel,
    input  logic [RW-1:0] ld_gpr,
    input  logic [DW-1:0] ld_data,
    output logic          mem_rd,
    output logic [AW-1:0] mem_addr,
    input  logic [DW-1:0] mem_rdata,
    output logic          busy,
    output logic          done,
    output logic          err,
    output logic [DW-1:0] acc_o,
    output logic [AW-1:0] idx_o
);
    amode_e        mode_w;
    xstep_e        step_w;
    ldtgt_e        tgt_w;
    logic          ld_ok;
    logic          acc_we_w, rx_we_w, rx_down_w;
    logic [DW-1:0] operand_w;
    logic [AW-1:0] rb_w, ri_w, ea_w;

    assign mode_w = amode_e'(mode_i);
    assign step_w = xstep_e'(idx_op_i);
    assign tgt_w  = ldtgt_e'(ld_sel);
    assign ld_ok  = ld_en && !busy;

    ofu_regfile #(.DW(DW), .AW(AW), .NGPR(NGPR), .RW(RW)) regs_i (
        .clk       (clk),
        .rst       (rst),
        .ld_we     (ld_ok),
        .ld_tgt    (tgt_w),
        .ld_gpr    (ld_gpr),
        .ld_data   (ld_data),
        .acc_we    (acc_we_w),
        .acc_addend(operand_w),
        .rx_we     (rx_we_w),
        .rx_down   (rx_down_w),
        .ri_sel    (ri_sel_i),
        .acc_q     (acc_o),
        .rx_q      (idx_o),
        .rb_q      (rb_w),
        .ri_q      (ri_w)
    );

    ofu_agen #(.AW(AW)) agen_i (
        .mode      (mode_w),
        .x_fld     (x_i),
        .ri_val    (ri_w),
        .rx_val    (idx_o),
        .rb_val    (rb_w),
        .first_addr(ea_w)
    );

    ofu_seq #(.DW(DW), .AW(AW), .MAX_IND(MAX_IND)) seq_i (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .mode_in   (mode_w),
        .step_in   (step_w),
        .x_in      (x_i),
        .first_addr(ea_w),
        .mem_rdata (mem_rdata),
        .mem_rd    (mem_rd),
        .mem_addr  (mem_addr),
        .busy      (busy),
        .done      (done),
        .err       (err),
        .acc_we    (acc_we_w),
        .operand   (operand_w),
        .rx_we     (rx_we_w),
        .rx_down   (rx_down_w)
    );

    logic ld_ac_w, ld_rx_w;
    assign ld_ac_w = ld_ok && (tgt_w == LT_AC);
    assign ld_rx_w = ld_ok && (tgt_w == LT_RX);

    // R3
    acc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!done && !$past(ld_ac_w)) |-> $stable(acc_o));

    // R8
    idx_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!done && !$past(ld_rx_w)) |-> $stable(idx_o));

    // R6
    err_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        err |-> ($stable(acc_o) && $stable(idx_o)));

endmodule

// File: tb/operand_fetch_unit_tb.sv
module operand_fetch_unit_tb_top;
    localparam int DW = 16, AW = 8, NGPR = 4, MAX_IND = 4, RW = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [2:0]    mode_i = '0;
    logic [1:0]    idx_op_i = '0;
    logic [RW-1:0] ri_sel_i = '0;
    logic [AW-1:0] x_i = '0;
    logic          ld_en = 1'b0;
    logic [1:0]    ld_sel = '0;
    logic [RW-1:0] ld_gpr = '0;
    logic [DW-1:0] ld_data = '0;
    logic          mem_rd;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_rdata = '0;
    logic          busy, done, err;
    logic [DW-1:0] acc_o;
    logic [AW-1:0] idx_o;

    int n_run = 0;
    int n_fail = 0;

    logic [DW-1:0] mem [256];
    logic [DW-1:0] m_ac;
    logic [AW-1:0] m_rx, m_rb;
    logic [AW-1:0] m_gpr [NGPR];

    always #10 clk = ~clk;

    always @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr];

    operand_fetch_unit #(.DW(DW), .AW(AW), .NGPR(NGPR), .MAX_IND(MAX_IND)) dut_i (
        .clk(clk), .rst(rst), .start(start), .mode_i(mode_i), .idx_op_i(idx_op_i),
        .ri_sel_i(ri_sel_i), .x_i(x_i), .ld_en(ld_en), .ld_sel(ld_sel),
        .ld_gpr(ld_gpr), .ld_data(ld_data), .mem_rd(mem_rd), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .busy(busy), .done(done), .err(err),
        .acc_o(acc_o), .idx_o(idx_o)
    );

    initial begin
        #3000000;
        n_run++; n_fail++;
        $display("FAIL watchdog: run did not finish (actual hung, expected finish)");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic load(input int sel, input int gi, input int data);
        @(negedge clk);
        ld_en = 1'b1; ld_sel = 2'(sel); ld_gpr = RW'(gi); ld_data = DW'(data);
        @(negedge clk);
        ld_en = 1'b0;
        case (sel)
            0: m_ac = DW'(data);
            1: m_rx = AW'(data);
            2: m_rb = AW'(data);
            default: m_gpr[gi] = AW'(data);
        endcase
    endtask

    // independent model of the requirement R2/R4/R5/R6
    task automatic model(input int mode, input int x, input int ri,
                         output logic [DW-1:0] opnd, output int reads, output logic fail);
        logic [AW-1:0] a;
        logic [DW-1:0] w;
        int depth;
        fail = 1'b0; reads = 0; opnd = '0;
        case (mode)
            0: begin opnd = DW'(x); return; end
            1: a = AW'(x);
            2: a = AW'(x);
            3: a = m_gpr[ri];
            4: a = m_gpr[ri];
            5: a = AW'(m_rb + AW'(x));
            6: a = AW'(AW'(x) + m_rx);
            default: a = AW'(m_rb + m_rx + AW'(x));
        endcase
        if (mode == 2 || mode == 4) begin
            depth = 0;
            forever begin
                w = mem[a]; reads++; depth++;
                a = w[AW-1:0];
                if (!(mode == 2 && w[DW-1])) break;
                if (depth == MAX_IND) begin fail = 1'b1; return; end
            end
        end
        opnd = mem[a]; reads++;
    endtask

    task automatic run_op(input int mode, input int step, input int x, input int ri, input string tag);
        logic [DW-1:0] opnd;
        int reads, bcnt, rcnt, guard;
        logic fail;
        logic [DW-1:0] exp_ac;
        logic [AW-1:0] exp_rx;
        model(mode, x, ri, opnd, reads, fail);
        exp_ac = fail ? m_ac : DW'(m_ac + opnd);
        exp_rx = m_rx;
        if (!fail && step == 1) exp_rx = AW'(m_rx + 1);
        if (!fail && step == 2) exp_rx = AW'(m_rx - 1);
        @(negedge clk);
        start = 1'b1; mode_i = 3'(mode); idx_op_i = 2'(step); x_i = AW'(x); ri_sel_i = RW'(ri);
        @(negedge clk);
        start = 1'b0;
        bcnt = 0; rcnt = 0; guard = 0;
        while (!done && guard < 100) begin
            if (busy) bcnt++;
            if (mem_rd) rcnt++;
            guard++;
            @(negedge clk);
        end
        chk(done === 1'b1, {tag, " R7 done seen"}, int'(done), 1);
        chk(acc_o === exp_ac, {tag, " R3 accumulator"}, int'(acc_o), int'(exp_ac));
        chk(err === fail, {tag, " R6 err flag"}, int'(err), int'(fail));
        chk(rcnt == reads, {tag, " R4 read count"}, rcnt, reads);
        chk(bcnt == 2 * reads + 1, {tag, " R7 busy length"}, bcnt, 2 * reads + 1);
        chk(idx_o === exp_rx, {tag, " R8 index step"}, int'(idx_o), int'(exp_rx));
        m_ac = exp_ac; m_rx = exp_rx;
        @(negedge clk);
        chk(done === 1'b0 && busy === 1'b0, {tag, " R7 single pulse"}, int'(done), 0);
    endtask

    initial begin
        for (int a = 0; a < 256; a++) mem[a] = DW'((a * 97 + 13) & 16'h3fff);
        m_ac = '0; m_rx = '0; m_rb = '0;
        for (int g = 0; g < NGPR; g++) m_gpr[g] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk(acc_o == 0 && idx_o == 0, "R1 reset registers", int'(acc_o), 0);
        chk(!busy && !done && !err && !mem_rd, "R1 reset controls", int'(busy), 0);

        // R10 worked example
        mem[100] = 16'd200; mem[200] = 16'd125; mem[250] = 16'd213;
        load(2, 0, 150);
        load(0, 0, 50); run_op(1, 0, 100, 0, "R10 direct");
        chk(acc_o == 250, "R10 direct value", int'(acc_o), 250);
        load(0, 0, 50); run_op(2, 0, 100, 0, "R10 indirect");
        chk(acc_o == 175, "R10 indirect value", int'(acc_o), 175);
        load(0, 0, 50); run_op(5, 0, 100, 0, "R10 based");
        chk(acc_o == 263, "R10 based value", int'(acc_o), 263);
        load(0, 0, 50); run_op(0, 0, 100, 0, "R10 immediate");
        chk(acc_o == 150, "R10 immediate value", int'(acc_o), 150);

        // R2 R4 R8 sweep over modes, steps, fields and registers
        for (int g = 0; g < NGPR; g++) load(3, g, 40 + 53 * g);
        load(0, 0, 16'hfff0);
        for (int m = 0; m < 8; m++) begin
            for (int s = 0; s < 4; s++) begin
                for (int xi = 0; xi < 4; xi++) begin
                    load(1, 0, (xi == 3) ? 255 : 7 * m + s);
                    load(2, 0, 200 + 11 * xi);
                    run_op(m, s, (xi == 0) ? 0 : 60 * xi + m, (m + xi) % NGPR, "R2 sweep");
                end
            end
        end
        // R8 wrap at zero going down
        load(1, 0, 0); run_op(6, 2, 5, 0, "R8 wrap down");
        chk(idx_o == 255, "R8 wrap value", int'(idx_o), 255);

        // R5 chains of depth 1..3 then operand, and R6 cap
        for (int d = 1; d < MAX_IND; d++) begin
            for (int k = 0; k < d; k++) mem[10 + k] = DW'(16'h8000 | (11 + k));
            mem[10 + d] = DW'(16'h4000 | 90);
            run_op(2, 1, 10, 0, "R5 chain");
            mem[10 + d] = DW'(((10 + d) * 97 + 13) & 16'h3fff);
        end
        for (int k = 0; k < MAX_IND; k++) mem[30 + k] = DW'(16'h8000 | (31 + k));
        load(1, 0, 77);
        run_op(2, 1, 30, 0, "R6 cap");
        chk(idx_o == 77, "R6 index untouched", int'(idx_o), 77);
        // R5 flag not followed outside indirect mode
        mem[120] = DW'(16'h8000 | 33);
        load(3, 1, 120);
        run_op(4, 0, 0, 1, "R5 regmem no chase");

        // R9 start and load while busy are ignored
        load(1, 0, 9);
        @(negedge clk);
        start = 1'b1; mode_i = 3'd1; idx_op_i = 2'd0; x_i = 8'd3;
        @(negedge clk);
        start = 1'b0;
        ld_en = 1'b1; ld_sel = 2'd1; ld_data = 16'd99;
        mode_i = 3'd0; x_i = 8'd1; start = 1'b1;
        @(negedge clk);
        ld_en = 1'b0; start = 1'b0;
        m_ac = DW'(m_ac + mem[3]);
        repeat (6) @(negedge clk);
        chk(idx_o == 9, "R9 load ignored while busy", int'(idx_o), 9);
        chk(acc_o == m_ac && !busy, "R9 start ignored while busy", int'(acc_o), int'(m_ac));

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule